// File: doc/BRIEF.md
# Informing-Load Data Cache

A small two-way set-associative data cache whose load requests carry an extra flag. A flagged ("informing") load acts exactly like a plain load while it hits. When it misses, the cache fills the line from a backing memory port as usual. In the same cycle that it returns the load data, it pulses a trap output carrying the line-aligned miss address. The core uses that pulse to branch to a handler that runs at user privilege. Plain loads never trap. A handler that must hide secret-dependent cache misses can therefore observe exactly the misses that matter to it.

Besides loads, the cache accepts prefetches and stores. A prefetch fills a missing line and returns nothing. Stores write through to memory and change the cached copy only if the line is already present; a store miss does not allocate a line. Each set keeps one recency bit that chooses the victim way. Requests use a valid/ready handshake, and `req_ready` stays low while a line fill is in flight.

Top module: `ild_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `trap_valid`, `mem_rd_req` and `mem_wr_valid` are 0. Reset invalidates every line, so a load to a previously cached line misses afterwards.
- R2: A load that hits returns its 32-bit word on `rsp_rdata`, with `rsp_valid` high in the cycle after acceptance, and issues no memory read.
- R3: A load that misses raises `mem_rd_req` in the cycle after acceptance, with `mem_rd_addr` equal to the request address with bits [5:0] cleared. The request is held until `mem_rd_ack`. In the cycle after the ack, `rsp_valid` returns word `addr[5:2]`, taken from bits [32k+31:32k] of `mem_rd_line`.
- R4: An informing load (`req_inform`=1, `req_op`=2'b00) that misses pulses `trap_valid` for exactly one cycle, in the same cycle as its `rsp_valid`, with `trap_addr` equal to the line-aligned miss address.
- R5: An informing load that hits returns the same data and timing as a plain load and raises no trap.
- R6: A plain load (`req_inform`=0) never raises `trap_valid`, whether it hits or misses.
- R7: Each set holds two lines. Set index is `addr[8:6]` with 8 sets, and two lines with the same index both hit after being filled.
- R8: On a miss into a full set, the way least recently touched by a hit or fill is replaced, and the other line still hits.
- R9: A prefetch (`req_op`=2'b10) that misses fills the line but returns no `rsp_valid` and no trap. A prefetch that hits issues no memory read.
- R10: A store (`req_op`=2'b01) pulses `mem_wr_valid` with its address and data in the cycle after acceptance. A store that hits updates the cached word. A store that misses does not allocate, so a later load to that line misses.
- R11: While a fill is outstanding `req_ready` is 0. A request held valid during the fill is accepted only once the fill has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request |
| req_op | input | 2 | 00 load, 01 store, 10 prefetch, 11 ignored |
| req_inform | input | 1 | Load traps on a miss |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 32 | Load data |
| trap_valid | output | 1 | One-cycle user-level trap pulse |
| trap_addr | output | 32 | Line-aligned miss address |
| mem_rd_req | output | 1 | Line fill request, held until ack |
| mem_rd_addr | output | 32 | Line-aligned fill address |
| mem_rd_ack | input | 1 | Fill data present on `mem_rd_line` |
| mem_rd_line | input | 512 | Fill line, word k at bits [32k+31:32k] |
| mem_wr_valid | output | 1 | Write-through pulse |
| mem_wr_addr | output | 32 | Store address |
| mem_wr_data | output | 32 | Store data |

## Verification
The bench concentrates on a single set that sees three conflicting lines. The sequence is built so that a design that evicted the most recently used way, or never updated recency on hits, would miss where a hit is expected. It checks that an informing hit stays silent and that a plain miss returns data without trapping. A design that keyed the trap on the miss alone, or on the flag alone, fails one of those rows. It also checks that prefetch fills give no response, that store misses leave the line absent, and that a request held during a fill waits for the fill to finish rather than being served from half-written state. A final reset confirms that lines do not survive reset.

// File: rtl/ild_pkg.sv
`timescale 1ns/1ps
package ild_pkg;
   typedef enum logic [1:0] {
      OP_LOAD   = 2'b00,
      OP_STORE  = 2'b01,
      OP_PFETCH = 2'b10,
      OP_NONE   = 2'b11
   } ild_op_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_FILL = 1'b1
   } ild_state_e;
endpackage

// File: rtl/ild_tag_ram.sv
`timescale 1ns/1ps
module ild_tag_ram #(
   parameter int SETS  = 8,
   parameter int WAYS  = 2,
   parameter int IDX_W = 3,
   parameter int TAG_W = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic [WAYS-1:0]  hit_vec,
   output logic [WAYS-1:0]  vld_vec,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_way,
   input  logic [TAG_W-1:0] wr_tag
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0] tag_q [SETS];
      logic [SETS-1:0]  vld_q;
      logic             sel;

      assign sel = wr_en && (wr_way == 1'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   vld_q <= '0;
         else if (sel) vld_q[wr_idx] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) tag_q[wr_idx] <= wr_tag;
      end

      assign vld_vec[w] = vld_q[lk_idx];
      assign hit_vec[w] = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   end
endmodule

// File: rtl/ild_lru.sv
`timescale 1ns/1ps
module ild_lru #(
   parameter int SETS  = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_idx,
   input  logic             touch_way,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             evict_way
);
   // One bit per set naming the way to evict next.
   logic [SETS-1:0] old_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        old_q <= '0;
      else if (touch_en) old_q[touch_idx] <= ~touch_way;
   end

   assign evict_way = old_q[rd_idx];
endmodule

// File: rtl/ild_line_ram.sv
`timescale 1ns/1ps
module ild_line_ram #(
   parameter int SETS   = 8,
   parameter int WAYS   = 2,
   parameter int IDX_W  = 3,
   parameter int LINE_W = 512,
   parameter int DATA_W = 32,
   parameter int WSEL_W = 4
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic              rd_way,
   input  logic [WSEL_W-1:0] rd_wsel,
   output logic [DATA_W-1:0] rd_word,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic              fill_way,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_way,
   input  logic [WSEL_W-1:0] wr_wsel,
   input  logic [DATA_W-1:0] wr_word
);
   logic [LINE_W-1:0] way_line [WAYS];
   logic [LINE_W-1:0] sel_line;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [LINE_W-1:0] line_q [SETS];

      always_ff @(posedge clk) begin
         if (fill_en && fill_way == 1'(w))
            line_q[fill_idx] <= fill_line;
         else if (wr_en && wr_way == 1'(w))
            line_q[wr_idx][wr_wsel*DATA_W +: DATA_W] <= wr_word;
      end

      assign way_line[w] = line_q[rd_idx];
   end

   assign sel_line = way_line[rd_way];
   assign rd_word  = sel_line[rd_wsel*DATA_W +: DATA_W];
endmodule

// File: rtl/ild_cache.sv
`timescale 1ns/1ps
module ild_cache
   import ild_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int SETS       = 8,
   parameter int WAYS       = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [1:0]                req_op,
   input  logic                      req_inform,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [DATA_W-1:0]         req_wdata,
   output logic                      rsp_valid,
   output logic [DATA_W-1:0]         rsp_rdata,
   output logic                      trap_valid,
   output logic [ADDR_W-1:0]         trap_addr,
   output logic                      mem_rd_req,
   output logic [ADDR_W-1:0]         mem_rd_addr,
   input  logic                      mem_rd_ack,
   input  logic [LINE_BYTES*8-1:0]   mem_rd_line,
   output logic                      mem_wr_valid,
   output logic [ADDR_W-1:0]         mem_wr_addr,
   output logic [DATA_W-1:0]         mem_wr_data
);
   localparam int LINE_W = LINE_BYTES * 8;
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
   localparam int BPW    = DATA_W / 8;
   localparam int BOFF_W = $clog2(BPW);
   localparam int WORDS  = LINE_BYTES / BPW;
   localparam int WSEL_W = $clog2(WORDS);

   initial begin
      assert (WAYS == 2) else $error("ild_cache: WAYS must be 2");
      assert (SETS >= 2 && (1 << IDX_W) == SETS) else $error("ild_cache: SETS must be a power of two >= 2");
      assert ((1 << OFF_W) == LINE_BYTES) else $error("ild_cache: LINE_BYTES must be a power of two");
      assert (DATA_W >= 16 && (1 << BOFF_W) * 8 == DATA_W) else $error("ild_cache: DATA_W must be a power-of-two byte count");
      assert (WORDS >= 2) else $error("ild_cache: line must hold two or more words");
      assert (TAG_W >= 1) else $error("ild_cache: address too narrow");
   end

   ild_state_e state_q;
   ild_op_e    op;

   logic [ADDR_W-1:BOFF_W] miss_addr_q;
   ild_op_e                miss_op_q;
   logic                   miss_inform_q;
   logic                   miss_way_q;

   logic [IDX_W-1:0]  lk_idx, miss_idx;
   logic [TAG_W-1:0]  lk_tag, miss_tag;
   logic [WSEL_W-1:0] lk_wsel, miss_wsel;
   logic [WAYS-1:0]   hit_vec, vld_vec;
   logic              hit, hit_way, evict_way, victim;
   logic              accept, fill_done, store_hit;
   logic              touch_en, touch_way;
   logic [IDX_W-1:0]  touch_idx;
   logic [DATA_W-1:0] hit_word;
   logic              unused_lo_bits;

   assign op        = ild_op_e'(req_op);
   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign fill_done = (state_q == ST_FILL) && mem_rd_ack;

   assign lk_idx    = req_addr[OFF_W +: IDX_W];
   assign lk_tag    = req_addr[ADDR_W-1 -: TAG_W];
   assign lk_wsel   = req_addr[BOFF_W +: WSEL_W];
   assign miss_idx  = miss_addr_q[OFF_W +: IDX_W];
   assign miss_tag  = miss_addr_q[ADDR_W-1 -: TAG_W];
   assign miss_wsel = miss_addr_q[BOFF_W +: WSEL_W];
   assign unused_lo_bits = ^req_addr[BOFF_W-1:0];

   assign hit     = |hit_vec;
   assign hit_way = hit_vec[1];
   assign victim  = !vld_vec[0] ? 1'b0 : (!vld_vec[1] ? 1'b1 : evict_way);

   assign store_hit = accept && (op == OP_STORE) && hit;
   assign touch_en  = fill_done || (accept && hit && (op != OP_NONE));
   assign touch_idx = fill_done ? miss_idx : lk_idx;
   assign touch_way = fill_done ? miss_way_q : hit_way;

   ild_tag_ram #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .lk_idx(lk_idx), .lk_tag(lk_tag), .hit_vec(hit_vec), .vld_vec(vld_vec),
      .wr_en(fill_done), .wr_idx(miss_idx), .wr_way(miss_way_q), .wr_tag(miss_tag)
   );

   ild_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
      .clk(clk), .rst_n(rst_n),
      .touch_en(touch_en), .touch_idx(touch_idx), .touch_way(touch_way),
      .rd_idx(lk_idx), .evict_way(evict_way)
   );

   ild_line_ram #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .LINE_W(LINE_W),
                  .DATA_W(DATA_W), .WSEL_W(WSEL_W)) u_lines (
      .clk(clk),
      .rd_idx(lk_idx), .rd_way(hit_way), .rd_wsel(lk_wsel), .rd_word(hit_word),
      .fill_en(fill_done), .fill_idx(miss_idx), .fill_way(miss_way_q), .fill_line(mem_rd_line),
      .wr_en(store_hit), .wr_idx(lk_idx), .wr_way(hit_way), .wr_wsel(lk_wsel), .wr_word(req_wdata)
   );

   assign mem_rd_req  = (state_q == ST_FILL);
   assign mem_rd_addr = {miss_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         miss_addr_q   <= '0;
         miss_op_q     <= OP_NONE;
         miss_inform_q <= 1'b0;
         miss_way_q    <= 1'b0;
         rsp_valid     <= 1'b0;
         rsp_rdata     <= '0;
         trap_valid    <= 1'b0;
         trap_addr     <= '0;
         mem_wr_valid  <= 1'b0;
         mem_wr_addr   <= '0;
         mem_wr_data   <= '0;
      end else begin
         rsp_valid    <= 1'b0;
         trap_valid   <= 1'b0;
         mem_wr_valid <= 1'b0;
         if (accept) begin
            unique case (op)
               OP_LOAD: begin
                  if (hit) begin
                     rsp_valid <= 1'b1;
                     rsp_rdata <= hit_word;
                  end
               end
               OP_STORE: begin
                  mem_wr_valid <= 1'b1;
                  mem_wr_addr  <= req_addr;
                  mem_wr_data  <= req_wdata;
               end
               default: ;
            endcase
            if (!hit && (op == OP_LOAD || op == OP_PFETCH)) begin
               state_q       <= ST_FILL;
               miss_addr_q   <= req_addr[ADDR_W-1:BOFF_W];
               miss_op_q     <= op;
               miss_inform_q <= req_inform;
               miss_way_q    <= victim;
            end
         end else if (fill_done) begin
            state_q <= ST_IDLE;
            if (miss_op_q == OP_LOAD) begin
               rsp_valid  <= 1'b1;
               rsp_rdata  <= mem_rd_line[miss_wsel*DATA_W +: DATA_W];
               trap_valid <= miss_inform_q;
               trap_addr  <= mem_rd_addr;
            end
         end
      end
   end
endmodule

// File: rtl/ild_cache_chk.sv
`timescale 1ns/1ps
module ild_cache_chk #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        req_op,
   input logic              rsp_valid,
   input logic              trap_valid,
   input logic [ADDR_W-1:0] trap_addr,
   input logic              mem_rd_req,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_rd_ack,
   input logic              mem_wr_valid
);
   p_trap_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |=> !trap_valid);
   p_trap_with_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> rsp_valid);
   p_trap_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> (trap_addr[OFF_W-1:0] == '0));
   p_trap_after_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> $past(mem_rd_req && mem_rd_ack));
   p_rd_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_ack) |=> mem_rd_req);
   p_rd_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> (mem_rd_addr[OFF_W-1:0] == '0));
   p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !req_ready);
   p_wr_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> $past(req_valid && req_ready && req_op == 2'b01));
   p_rsp_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past((req_valid && req_ready && req_op == 2'b00) || (mem_rd_req && mem_rd_ack)));
endmodule

bind ild_cache ild_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_op(req_op), .rsp_valid(rsp_valid), .trap_valid(trap_valid),
   .trap_addr(trap_addr), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
   .mem_rd_ack(mem_rd_ack), .mem_wr_valid(mem_wr_valid)
);

// File: tb/tb_ild_cache.sv
`timescale 1ns/1ps
module tb_ild_cache;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [1:0]   req_op = 2'b00;
   logic         req_inform = 1'b0;
   logic [31:0]  req_addr = '0;
   logic [31:0]  req_wdata = '0;
   logic         rsp_valid;
   logic [31:0]  rsp_rdata;
   logic         trap_valid;
   logic [31:0]  trap_addr;
   logic         mem_rd_req;
   logic [31:0]  mem_rd_addr;
   logic         mem_rd_ack = 1'b0;
   logic [511:0] mem_rd_line = '0;
   logic         mem_wr_valid;
   logic [31:0]  mem_wr_addr;
   logic [31:0]  mem_wr_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   ild_cache dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_inform(req_inform), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .trap_valid(trap_valid), .trap_addr(trap_addr),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
      .mem_rd_line(mem_rd_line), .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return {a[31:6], 6'b0} ^ (32'h0101_0101 * {28'h0, a[5:2]}) ^ 32'hC0DE_0000;
   endfunction

   function automatic logic [511:0] mem_line(input logic [31:0] a);
      logic [511:0] l;
      for (int k = 0; k < 16; k++) l[k*32 +: 32] = mem_word({a[31:6], 4'(k), 2'b00});
      return l;
   endfunction

   typedef struct packed {
      logic [1:0]  op;
      logic        inf;
      logic [31:0] addr;
      logic [31:0] wdata;
      logic        miss;
      logic        trap;
      logic [31:0] data;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{2'b00, 1'b0, 32'h1004, 32'h0,         1'b1, 1'b0, mem_word(32'h1004)}, // R3 R6 plain miss
      '{2'b00, 1'b0, 32'h1008, 32'h0,         1'b0, 1'b0, mem_word(32'h1008)}, // R2 hit
      '{2'b00, 1'b1, 32'h2010, 32'h0,         1'b1, 1'b1, mem_word(32'h2010)}, // R4 informing miss
      '{2'b00, 1'b1, 32'h2014, 32'h0,         1'b0, 1'b0, mem_word(32'h2014)}, // R5 informing hit
      '{2'b00, 1'b0, 32'h1000, 32'h0,         1'b0, 1'b0, mem_word(32'h1000)}, // R7 both ways held
      '{2'b00, 1'b1, 32'h3000, 32'h0,         1'b1, 1'b1, mem_word(32'h3000)}, // R8 evicts 0x2000
      '{2'b00, 1'b0, 32'h103C, 32'h0,         1'b0, 1'b0, mem_word(32'h103C)}, // R8 survivor hits
      '{2'b00, 1'b1, 32'h2000, 32'h0,         1'b1, 1'b1, mem_word(32'h2000)}, // R8 evicted line misses
      '{2'b10, 1'b1, 32'h4040, 32'h0,         1'b1, 1'b0, 32'h0},              // R9 prefetch miss
      '{2'b00, 1'b1, 32'h4044, 32'h0,         1'b0, 1'b0, mem_word(32'h4044)}, // R9 prefetched line hits
      '{2'b10, 1'b0, 32'h4040, 32'h0,         1'b0, 1'b0, 32'h0},              // R9 prefetch hit
      '{2'b01, 1'b0, 32'h4048, 32'hDEADBEEF,  1'b0, 1'b0, 32'hDEADBEEF},       // R10 store hit
      '{2'b00, 1'b0, 32'h4048, 32'h0,         1'b0, 1'b0, 32'hDEADBEEF},       // R10 updated word
      '{2'b01, 1'b1, 32'h5000, 32'h1234_5678, 1'b0, 1'b0, 32'h1234_5678},      // R10 store miss
      '{2'b00, 1'b0, 32'h5008, 32'h0,         1'b1, 1'b0, mem_word(32'h5008)}  // R10 R6 no allocate
   };

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // Serve a pending fill after a few cycles; call at a negedge with mem_rd_req high.
   task automatic serve_fill(input logic [31:0] a);
      repeat (2) begin
         @(negedge clk);
         chk(req_ready == 1'b0, "R11 ready low during fill", 32'(req_ready), 32'h0);
      end
      mem_rd_line = mem_line(a);
      mem_rd_ack  = 1'b1;
      @(negedge clk);
      mem_rd_ack  = 1'b0;
   endtask

   task automatic run_vec(input vec_t v);
      logic [31:0] la;
      la = {v.addr[31:6], 6'b0};
      @(negedge clk);
      req_valid = 1'b1; req_op = v.op; req_inform = v.inf;
      req_addr = v.addr; req_wdata = v.wdata;
      @(negedge clk);
      req_valid = 1'b0;
      if (v.miss) begin
         chk(mem_rd_req == 1'b1, "R3 fill requested", 32'(mem_rd_req), 32'h1);
         chk(mem_rd_addr == la, "R3 fill address", mem_rd_addr, la);
         serve_fill(v.addr);
      end else begin
         chk(mem_rd_req == 1'b0, "R2 no memory read", 32'(mem_rd_req), 32'h0);
      end
      if (v.op == 2'b00) begin
         chk(rsp_valid == 1'b1, "R2/R3 response valid", 32'(rsp_valid), 32'h1);
         chk(rsp_rdata == v.data, "R2/R3 load data", rsp_rdata, v.data);
      end else begin
         chk(rsp_valid == 1'b0, "R9 no response", 32'(rsp_valid), 32'h0);
      end
      if (v.trap) begin
         chk(trap_valid == 1'b1, "R4 trap raised", 32'(trap_valid), 32'h1);
         chk(trap_addr == la, "R4 trap address", trap_addr, la);
      end else begin
         chk(trap_valid == 1'b0, "R5/R6 no trap", 32'(trap_valid), 32'h0);
      end
      if (v.op == 2'b01) begin
         chk(mem_wr_valid == 1'b1, "R10 write-through", 32'(mem_wr_valid), 32'h1);
         chk(mem_wr_addr == v.addr, "R10 write address", mem_wr_addr, v.addr);
         chk(mem_wr_data == v.data, "R10 write data", mem_wr_data, v.data);
      end
      @(negedge clk);
      chk(trap_valid == 1'b0, "R4 trap one cycle", 32'(trap_valid), 32'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
      chk(rsp_valid == 1'b0, "R1 rsp idle", 32'(rsp_valid), 32'h0);
      chk(trap_valid == 1'b0, "R1 trap idle", 32'(trap_valid), 32'h0);
      chk(mem_rd_req == 1'b0, "R1 no fill", 32'(mem_rd_req), 32'h0);
      chk(mem_wr_valid == 1'b0, "R1 no write", 32'(mem_wr_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R11: request held during a fill is taken only after the fill
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'b00; req_inform = 1'b1; req_addr = 32'h7000;
      @(negedge clk);
      req_addr = 32'h7004; req_inform = 1'b0;
      chk(mem_rd_req == 1'b1, "R11 fill started", 32'(mem_rd_req), 32'h1);
      serve_fill(32'h7000);
      chk(rsp_valid && rsp_rdata == mem_word(32'h7000), "R11 first load data", rsp_rdata, mem_word(32'h7000));
      chk(trap_valid == 1'b1, "R4 trap on held-request miss", 32'(trap_valid), 32'h1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid && rsp_rdata == mem_word(32'h7004), "R11 held request served as hit", rsp_rdata, mem_word(32'h7004));
      chk(mem_rd_req == 1'b0, "R11 held request no refill", 32'(mem_rd_req), 32'h0);

      // R1: reset invalidates lines
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      run_vec('{2'b00, 1'b0, 32'h4044, 32'h0, 1'b1, 1'b0, mem_word(32'h4044)}); // R1 line gone

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule